// File: doc/BRIEF.md
# Descriptor Ring Audio DMA Channel

This block is the bookkeeping half of one playback or capture channel in an audio bus-master DMA engine. Software builds a ring of 32 buffer descriptors in system memory, each 8 bytes long, and points the channel at the ring. Once the channel is started, it fetches one descriptor at a time through a simple 32-bit read port. It loads that buffer's sample count and then counts down one sample for each pulse on the sample strobe. A separate data mover drives that strobe; the channel gives it the current buffer address.

When a buffer runs out, the channel either moves on to the next ring entry or, if that buffer was the last one software marked valid, halts and raises status. Software can restart a halted channel by moving the last-valid index. Status flags can be cleared by writing 1 to them, and they drive one interrupt request, gated by enables in the control register. The channel's registers are reached through a byte, word and longword register port.

Top module: `ring_dma_chan`

## Requirements
- R1: The ring base register, at longword offset 0x0, forces its low 3 bits to zero. Writing 0x5555_555F reads back as 0x5555_5558.
- R2: After reset, status (word 0x6) reads 0x0001 and every other register reads 0. Writes to the current index (byte 0x4), the prefetch index (byte 0xA) and the remaining count (word 0x8) have no effect.
- R3: Writing control (byte 0xB) with run (bit 0) set while the channel is stopped has these effects. The current index becomes 0, the prefetch index becomes 1 and halted (status bit 0) clears. The next cycle requests the word at base+index*8. Bits 31:2 of that word, with the low 2 bits zeroed, become the buffer address. A second read at base+index*8+4 follows, whose bits 15:0 are the sample count and whose bit 31 requests a completion flag.
- R4: The remaining count (word 0x8) loads from the descriptor and drops by one on each sample strobe. The buffer completes on the strobe that takes the count to zero.
- R5: On completion, the buffer-complete flag (status bit 3) sets only if the descriptor's bit 31 was set.
- R6: A completed buffer that is not the last-valid one moves the current index to the prefetch value. The prefetch index then advances modulo 32, wrapping from 31 to 0, and the next descriptor fetch starts.
- R7: A completed buffer whose index equals the last-valid index sets halted (bit 0), current-equals-last (bit 1) and last-valid-complete (bit 2). No further fetch or count follows.
- R8: The last-valid index (byte 0x5) is stored modulo 32. While running and halted, writing a value other than the current index clears bits 0 and 1, advances the current index to the prefetch value and fetches that descriptor. Writing the current value leaves the channel halted.
- R9: Status bits 2 and 3 clear when 1 is written to them. The other status bits ignore writes, so writing 0xFFFF after reset leaves 0x0001.
- R10: The interrupt request is high when status bit 2 and control bit 2 are both set, or when status bit 3 and control bit 3 are both set.
- R11: Writing control with run clear stops the channel, sets halted and drops the memory request.
- R12: Writing control with bit 1 set returns every register to its reset value and abandons any fetch in progress. Bit 1 reads back as 0.
- R13: A descriptor with a sample count of zero leaves the channel waiting. The current index does not advance, halted stays clear, and sample strobes have no effect.
- R14: A longword read at 0x4 returns the current index in bits 7:0, the last-valid index in bits 15:8 and status in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_size | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data, right-aligned |
| reg_rdata | output | 32 | Read data for the addressed register, right-aligned |
| mem_req | output | 1 | Descriptor read request, held until acknowledged |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Read acknowledge, with data in the same cycle |
| mem_rdata | input | 32 | Descriptor word read data |
| smp_strobe | input | 1 | One sample of the current buffer has been moved |
| buf_addr | output | 32 | Address of the current buffer |
| xfer_active | output | 1 | A non-empty buffer is being counted |
| irq | output | 1 | Channel interrupt request |

## Verification
Register reads are combinational and register writes take effect at the clock edge of the write. The bench therefore reads back half a cycle after the write edge. A run start or a non-final completion shows its new request and address in the cycle right after its edge, and the bench checks them there. A descriptor fetch then takes two acknowledged cycles before counting starts, so the bench waits at least that long before pulsing the strobe. Completion status, index movement and the interrupt are checked half a cycle after the strobe edge that ends a buffer.

// File: rtl/ring_dma_pkg.sv
// Shared encodings for the descriptor ring DMA channel.
// Assumes: register offsets are byte offsets inside one channel window.
package ring_dma_pkg;

    // Access size codes on the register port
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;

    // Register byte offsets
    localparam logic [3:0] OFS_BASE = 4'h0;
    localparam logic [3:0] OFS_CUR  = 4'h4;
    localparam logic [3:0] OFS_LAST = 4'h5;
    localparam logic [3:0] OFS_STS  = 4'h6;
    localparam logic [3:0] OFS_REM  = 4'h8;
    localparam logic [3:0] OFS_PRE  = 4'hA;
    localparam logic [3:0] OFS_CTL  = 4'hB;

    // Status bit positions
    localparam int STS_HALT = 0;
    localparam int STS_CEQL = 1;
    localparam int STS_LVC  = 2;
    localparam int STS_BC   = 3;

    // Control bit positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_RST  = 1;
    localparam int CTL_LVIE = 2;
    localparam int CTL_BCIE = 3;

    // Descriptor completion-request bit in the second word
    localparam int DESC_IRQ_BIT = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_PTR,
        ST_REQ_CTL,
        ST_XFER,
        ST_EMPTY,
        ST_STALL
    } chan_state_e;

endpackage

// File: rtl/ring_dma_regdec.sv
// Register port decode for one DMA channel.
// Turns (offset, size, write) into per-register write strobes with the
// write data already trimmed, and muxes read data by offset and size.
// Assumes: unsupported offset/size pairs read 0 and ignore writes.
module ring_dma_regdec
    import ring_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 16
) (
    input  logic [3:0]        reg_addr,
    input  logic [1:0]        reg_size,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              base_we,
    output logic [ADDR_W-1:0] base_wdata,
    output logic              last_we,
    output logic [IDX_W-1:0]  last_wdata,
    output logic              sts_we,
    output logic              clr_lvc,
    output logic              clr_bc,
    output logic              ctl_we,
    output logic              ctl_run,
    output logic              ctl_rst,
    output logic              ctl_lvie,
    output logic              ctl_bcie,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [IDX_W-1:0]  cur_q,
    input  logic [IDX_W-1:0]  last_q,
    input  logic [IDX_W-1:0]  pre_q,
    input  logic [15:0]       sts_word,
    input  logic [7:0]        ctl_word,
    input  logic [CNT_W-1:0]  rem_q
);

    logic [5:0] sel;
    assign sel = {reg_size, reg_addr};

    // Write strobes: only writable registers at their native sizes
    always_comb begin
        base_we = reg_wr && (sel == {SZ_LONG, OFS_BASE});
        last_we = reg_wr && (sel == {SZ_BYTE, OFS_LAST});
        sts_we  = reg_wr && ((sel == {SZ_BYTE, OFS_STS}) || (sel == {SZ_WORD, OFS_STS}));
        ctl_we  = reg_wr && (sel == {SZ_BYTE, OFS_CTL});
    end

    // Write data slices: base loses its low three bits here
    assign base_wdata = {reg_wdata[ADDR_W-1:3], 3'b000};
    assign last_wdata = reg_wdata[IDX_W-1:0];
    assign clr_lvc    = reg_wdata[STS_LVC];
    assign clr_bc     = reg_wdata[STS_BC];
    assign ctl_run    = reg_wdata[CTL_RUN];
    assign ctl_rst    = reg_wdata[CTL_RST];
    assign ctl_lvie   = reg_wdata[CTL_LVIE];
    assign ctl_bcie   = reg_wdata[CTL_BCIE];

    // Read mux by offset and size
    always_comb begin
        case (sel)
            {SZ_LONG, OFS_BASE}: reg_rdata = 32'(base_q);
            {SZ_LONG, OFS_CUR}:  reg_rdata = {sts_word, 8'(last_q), 8'(cur_q)};
            {SZ_BYTE, OFS_CUR}:  reg_rdata = 32'(cur_q);
            {SZ_BYTE, OFS_LAST}: reg_rdata = 32'(last_q);
            {SZ_BYTE, OFS_STS}:  reg_rdata = 32'(sts_word[7:0]);
            {SZ_WORD, OFS_STS}:  reg_rdata = 32'(sts_word);
            {SZ_WORD, OFS_REM}:  reg_rdata = 32'(rem_q);
            {SZ_BYTE, OFS_PRE}:  reg_rdata = 32'(pre_q);
            {SZ_BYTE, OFS_CTL}:  reg_rdata = 32'(ctl_word);
            default:             reg_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/ring_dma_remcount.sv
// Remaining-sample counter for the buffer in flight.
// Loads from a fetched descriptor, counts down one per strobe and
// flags the final sample. Assumes load and decrement never coincide.
module ring_dma_remcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] rem_q,
    output logic             on_last
);

    // Count register: clear, load or decrement
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (dec && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    // Final-sample flag for the sequencer
    assign on_last = (rem_q == CNT_W'(1));

    // R4: each strobe takes exactly one sample off a running count
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !clr && rem_q > CNT_W'(1)) |=> (rem_q == $past(rem_q) - 1'b1));

    // R4: a load places the descriptor count unchanged
    assert_count_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (rem_q == $past(load_val)));

endmodule

// File: rtl/ring_dma_seq.sv
// Channel sequencer: holds base, indices, status and control, walks the
// descriptor ring and decides completion, advance, halt and resume.
// Assumes: the memory acknowledges with data in the same cycle, tolerates
// a request withdrawn before acknowledge, and the ring has 2**IDX_W entries.
module ring_dma_seq
    import ring_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              last_we,
    input  logic [IDX_W-1:0]  last_wdata,
    input  logic              sts_we,
    input  logic              clr_lvc,
    input  logic              clr_bc,
    input  logic              ctl_we,
    input  logic              ctl_run,
    input  logic              ctl_rst,
    input  logic              ctl_lvie,
    input  logic              ctl_bcie,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              smp_strobe,
    input  logic              rem_last,
    output logic              rem_clr,
    output logic              rem_load,
    output logic [CNT_W-1:0]  rem_load_val,
    output logic              rem_dec,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              xfer_active,
    output logic              irq,
    output logic [ADDR_W-1:0] base_q,
    output logic [IDX_W-1:0]  cur_q,
    output logic [IDX_W-1:0]  last_q,
    output logic [IDX_W-1:0]  pre_q,
    output logic [15:0]       sts_word,
    output logic [7:0]        ctl_word
);

    localparam int DESC_SHIFT = 3;

    chan_state_e state_q;
    logic halt_q, ceql_q, lvc_q, bc_q;
    logic run_q, lvie_q, bcie_q;
    logic desc_irq_q;
    logic fsm_en, wipe, done, done_last;
    logic [ADDR_W-1:0] desc_addr;

    // A control write that resets, stops or starts overrides the walker
    assign wipe   = ctl_we && ctl_rst;
    assign fsm_en = !(ctl_we && (ctl_rst || !ctl_run || !run_q));

    // Counter handshakes
    assign rem_clr      = wipe;
    assign rem_load     = fsm_en && state_q == ST_REQ_CTL && mem_ack;
    assign rem_load_val = mem_rdata[CNT_W-1:0];
    assign rem_dec      = fsm_en && state_q == ST_XFER && smp_strobe;
    assign done         = rem_dec && rem_last;
    assign done_last    = done && (cur_q == last_q);

    // Descriptor address and memory request
    assign desc_addr   = base_q + (ADDR_W'(cur_q) << DESC_SHIFT);
    assign mem_req     = (state_q == ST_REQ_PTR) || (state_q == ST_REQ_CTL);
    assign mem_addr    = (state_q == ST_REQ_CTL) ? desc_addr + ADDR_W'(4) : desc_addr;
    assign xfer_active = (state_q == ST_XFER);

    // Register views and interrupt
    assign sts_word = 16'({bc_q, lvc_q, ceql_q, halt_q});
    assign ctl_word = 8'({bcie_q, lvie_q, 1'b0, run_q});
    assign irq      = (lvc_q && lvie_q) || (bc_q && bcie_q);

    // Channel state: register writes, then walker progress (hardware sets win)
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            state_q    <= ST_IDLE;
            base_q     <= '0;
            cur_q      <= '0;
            last_q     <= '0;
            pre_q      <= '0;
            halt_q     <= 1'b1;
            ceql_q     <= 1'b0;
            lvc_q      <= 1'b0;
            bc_q       <= 1'b0;
            run_q      <= 1'b0;
            lvie_q     <= 1'b0;
            bcie_q     <= 1'b0;
            desc_irq_q <= 1'b0;
            buf_addr   <= '0;
        end else begin
            if (base_we) base_q <= base_wdata;
            if (last_we) last_q <= last_wdata;
            if (sts_we && clr_lvc) lvc_q <= 1'b0;
            if (sts_we && clr_bc)  bc_q  <= 1'b0;
            if (ctl_we) begin
                run_q  <= ctl_run;
                lvie_q <= ctl_lvie;
                bcie_q <= ctl_bcie;
                if (!ctl_run) begin
                    state_q <= ST_IDLE;
                    halt_q  <= 1'b1;
                end else if (!run_q) begin
                    cur_q   <= '0;
                    pre_q   <= IDX_W'(1);
                    halt_q  <= 1'b0;
                    state_q <= ST_REQ_PTR;
                end
            end
            if (fsm_en) begin
                case (state_q)
                    ST_REQ_PTR: if (mem_ack) begin
                        buf_addr <= {mem_rdata[ADDR_W-1:2], 2'b00};
                        state_q  <= ST_REQ_CTL;
                    end
                    ST_REQ_CTL: if (mem_ack) begin
                        desc_irq_q <= mem_rdata[DESC_IRQ_BIT];
                        state_q    <= (mem_rdata[CNT_W-1:0] == '0) ? ST_EMPTY : ST_XFER;
                    end
                    ST_XFER: if (done) begin
                        if (desc_irq_q) bc_q <= 1'b1;
                        if (done_last) begin
                            halt_q  <= 1'b1;
                            ceql_q  <= 1'b1;
                            lvc_q   <= 1'b1;
                            state_q <= ST_STALL;
                        end else begin
                            cur_q   <= pre_q;
                            pre_q   <= pre_q + 1'b1;
                            state_q <= ST_REQ_PTR;
                        end
                    end
                    ST_STALL: if (last_we && last_wdata != cur_q) begin
                        halt_q  <= 1'b0;
                        ceql_q  <= 1'b0;
                        cur_q   <= pre_q;
                        pre_q   <= pre_q + 1'b1;
                        state_q <= ST_REQ_PTR;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: a start from stopped lands on entry 0 with prefetch 1 and halted clear
    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_run && !ctl_rst && !run_q)
        |=> (cur_q == '0 && pre_q == IDX_W'(1) && !halt_q && mem_req));

    // R3: an unacknowledged request holds its address
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !ctl_we && !base_we) |=> (mem_req && $stable(mem_addr)));

    // R6: a non-final completion moves current to the old prefetch value
    assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_last && fsm_en)
        |=> (cur_q == $past(pre_q) && pre_q == IDX_W'($past(pre_q) + 1'b1)));

    // R6: while the ring is active the prefetch leads the current index by one
    assert_pre_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (pre_q == IDX_W'(cur_q + 1'b1)));

    // R7: a stalled channel always shows halted and current-equals-last
    assert_stall_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |-> (halt_q && ceql_q && !mem_req));

    // R11: clearing run drops the request and reports halted
    assert_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_run && !ctl_rst) |=> (!mem_req && halt_q && !xfer_active));

endmodule

// File: rtl/ring_dma_chan.sv
// Top of one descriptor ring audio DMA channel: register decode,
// channel sequencer and remaining-sample counter.
// Assumes: one register access per cycle, reads are combinational.
module ring_dma_chan #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_addr,
    input  logic [1:0]        reg_size,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              smp_strobe,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              xfer_active,
    output logic              irq
);

    logic              base_we, last_we, sts_we, ctl_we;
    logic [ADDR_W-1:0] base_wdata, base_q;
    logic [IDX_W-1:0]  last_wdata, cur_q, last_q, pre_q;
    logic              clr_lvc, clr_bc;
    logic              ctl_run, ctl_rst, ctl_lvie, ctl_bcie;
    logic [15:0]       sts_word;
    logic [7:0]        ctl_word;
    logic [CNT_W-1:0]  rem_q, rem_load_val;
    logic              rem_clr, rem_load, rem_dec, rem_last;

    ring_dma_regdec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dec (
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .base_we(base_we), .base_wdata(base_wdata),
        .last_we(last_we), .last_wdata(last_wdata),
        .sts_we(sts_we), .clr_lvc(clr_lvc), .clr_bc(clr_bc),
        .ctl_we(ctl_we), .ctl_run(ctl_run), .ctl_rst(ctl_rst),
        .ctl_lvie(ctl_lvie), .ctl_bcie(ctl_bcie),
        .base_q(base_q), .cur_q(cur_q), .last_q(last_q), .pre_q(pre_q),
        .sts_word(sts_word), .ctl_word(ctl_word), .rem_q(rem_q)
    );

    ring_dma_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .base_we(base_we), .base_wdata(base_wdata),
        .last_we(last_we), .last_wdata(last_wdata),
        .sts_we(sts_we), .clr_lvc(clr_lvc), .clr_bc(clr_bc),
        .ctl_we(ctl_we), .ctl_run(ctl_run), .ctl_rst(ctl_rst),
        .ctl_lvie(ctl_lvie), .ctl_bcie(ctl_bcie),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .smp_strobe(smp_strobe),
        .rem_last(rem_last), .rem_clr(rem_clr), .rem_load(rem_load),
        .rem_load_val(rem_load_val), .rem_dec(rem_dec),
        .mem_req(mem_req), .mem_addr(mem_addr), .buf_addr(buf_addr),
        .xfer_active(xfer_active), .irq(irq),
        .base_q(base_q), .cur_q(cur_q), .last_q(last_q), .pre_q(pre_q),
        .sts_word(sts_word), .ctl_word(ctl_word)
    );

    ring_dma_remcount #(.CNT_W(CNT_W)) u_rem (
        .clk(clk), .rst_n(rst_n), .clr(rem_clr), .load(rem_load),
        .load_val(rem_load_val), .dec(rem_dec),
        .rem_q(rem_q), .on_last(rem_last)
    );

endmodule

// File: tb/tb_ring_dma_chan.sv
module tb_ring_dma_chan;

    localparam int CLK_PERIOD = 20;
    localparam int NVEC = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        smp_strobe = 1'b0;
    logic [31:0] buf_addr;
    logic        xfer_active;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ring_dma_chan dut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .smp_strobe(smp_strobe),
        .buf_addr(buf_addr), .xfer_active(xfer_active), .irq(irq)
    );

    // Descriptor memory model. Ring A at 0x1000: entry i points to
    // 0x2000_0003 + i*0x100, counts 2 + i%3 (entry 5 counts 0), odd entries
    // request completion. Ring B at 0x4000: count 1, no request.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        int idx;
        idx = int'(a[7:3]);
        if (a >= 32'h1000 && a < 32'h1100) begin
            if (a[2] == 1'b0) return 32'h2000_0003 + 32'(idx * 32'h100);
            return ((idx % 2) == 1 ? 32'h8000_0000 : 32'h0) |
                   (idx == 5 ? 32'd0 : 32'(2 + idx % 3));
        end
        if (a >= 32'h4000 && a < 32'h4100) begin
            if (a[2] == 1'b0) return 32'h3000_0000 + 32'(idx * 32'h40);
            return 32'd1;
        end
        return 32'hDEAD_BEEF;
    endfunction

    always_comb begin
        mem_ack   = mem_req;
        mem_rdata = mem_word(mem_addr);
    end

    // Register-port vectors: {write, offset, size, data, expected read}
    localparam logic [70:0] VEC [NVEC] = '{
        {1'b0, 4'h0, 2'd2, 32'h0,         32'h0},          // R2 base resets to 0
        {1'b0, 4'h6, 2'd1, 32'h0,         32'h0000_0001},  // R2 status reset
        {1'b0, 4'h4, 2'd0, 32'h0,         32'h0},          // R2 current index reset
        {1'b1, 4'h6, 2'd1, 32'hFFFF,      32'h0},          // R9 write all ones
        {1'b0, 4'h6, 2'd1, 32'h0,         32'h0000_0001},  // R9 only halted remains
        {1'b1, 4'h0, 2'd2, 32'h5555_555F, 32'h0},          // R1 base write
        {1'b0, 4'h0, 2'd2, 32'h0,         32'h5555_5558},  // R1 low bits dropped
        {1'b1, 4'h4, 2'd0, 32'h07,        32'h0},          // R2 current index write
        {1'b0, 4'h4, 2'd0, 32'h0,         32'h0},          // R2 ignored
        {1'b1, 4'hA, 2'd0, 32'h09,        32'h0},          // R2 prefetch write
        {1'b0, 4'hA, 2'd0, 32'h0,         32'h0},          // R2 ignored
        {1'b1, 4'h8, 2'd1, 32'h1234,      32'h0},          // R2 count write
        {1'b0, 4'h8, 2'd1, 32'h0,         32'h0},          // R2 ignored
        {1'b1, 4'h5, 2'd0, 32'h3F,        32'h0},          // R8 last-valid write
        {1'b0, 4'h5, 2'd0, 32'h0,         32'h1F},         // R8 kept modulo 32
        {1'b1, 4'hB, 2'd0, 32'h0C,        32'h0},          // R10 enables only
        {1'b0, 4'hB, 2'd0, 32'h0,         32'h0C},         // R10 enables read back
        {1'b0, 4'h4, 2'd2, 32'h0,         32'h0001_1F00},  // R14 packed view
        {1'b1, 4'hB, 2'd0, 32'h02,        32'h0},          // R12 register reset
        {1'b0, 4'h0, 2'd2, 32'h0,         32'h0},          // R12 base cleared
        {1'b0, 4'h5, 2'd0, 32'h0,         32'h0},          // R12 last-valid cleared
        {1'b0, 4'hB, 2'd0, 32'h0,         32'h0},          // R12 control cleared
        {1'b0, 4'h6, 2'd1, 32'h0,         32'h0000_0001}   // R12 status reset value
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_size = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Combinational read half a cycle away from the edge
    task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] v);
        reg_addr = a; reg_size = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic strobe();
        @(negedge clk);
        smp_strobe = 1'b1;
        @(negedge clk);
        smp_strobe = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=timeout exp=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R2: reset state at the ports
        chk("R2 mem_req idle", 32'(mem_req), 32'd0);
        chk("R2 irq idle", 32'(irq), 32'd0);
        chk("R2 xfer idle", 32'(xfer_active), 32'd0);

        // Vector walk over the register port
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][70]) begin
                wr(VEC[i][69:66], VEC[i][65:64], VEC[i][63:32]);
            end else begin
                rd(VEC[i][69:66], VEC[i][65:64], v);
                chk($sformatf("vector %0d", i), v, VEC[i][31:0]);
            end
        end

        // Ring A: base 0x1000, last-valid 2, run with both enables
        wr(4'h0, 2'd2, 32'h1000);
        wr(4'h5, 2'd0, 32'h02);
        wr(4'hB, 2'd0, 32'h0D);
        chk("R3 request after start", 32'(mem_req), 32'd1);
        chk("R3 first address", mem_addr, 32'h1000);
        rd(4'h4, 2'd0, v); chk("R3 current 0", v, 32'd0);
        rd(4'hA, 2'd0, v); chk("R3 prefetch 1", v, 32'd1);
        rd(4'h6, 2'd1, v); chk("R3 halted clear", v, 32'd0);
        tick(3);
        chk("R3 buffer address aligned", buf_addr, 32'h2000_0000);
        chk("R3 counting", 32'(xfer_active), 32'd1);
        rd(4'h8, 2'd1, v); chk("R3 count loaded", v, 32'd2);
        strobe();
        rd(4'h8, 2'd1, v); chk("R4 count after one strobe", v, 32'd1);
        strobe();
        rd(4'h6, 2'd1, v); chk("R5 no flag without request", v, 32'd0);
        rd(4'h4, 2'd0, v); chk("R6 current advanced", v, 32'd1);
        rd(4'hA, 2'd0, v); chk("R6 prefetch advanced", v, 32'd2);
        chk("R6 next fetch address", mem_addr, 32'h1008);

        // Entry 1: three samples, completion requested
        tick(3);
        chk("R3 second buffer address", buf_addr, 32'h2000_0100);
        repeat (3) strobe();
        rd(4'h6, 2'd1, v); chk("R5 buffer-complete set", v, 32'h0008);
        chk("R10 irq from buffer-complete", 32'(irq), 32'd1);
        wr(4'h6, 2'd1, 32'h0008);
        rd(4'h6, 2'd1, v); chk("R9 write-one clears", v, 32'h0000);
        chk("R10 irq drops", 32'(irq), 32'd0);

        // Entry 2 is the last valid one: four samples then halt
        tick(3);
        repeat (4) strobe();
        rd(4'h6, 2'd1, v); chk("R7 halt flags", v, 32'h0007);
        chk("R7 no request", 32'(mem_req), 32'd0);
        chk("R10 irq from last-valid", 32'(irq), 32'd1);
        rd(4'h4, 2'd0, v); chk("R7 current held", v, 32'd2);
        strobe();
        rd(4'h8, 2'd1, v); chk("R7 strobe ignored after halt", v, 32'd0);

        // Resume via last-valid moves
        wr(4'h5, 2'd0, 32'h02);
        rd(4'h6, 2'd1, v); chk("R8 same index stays halted", v, 32'h0007);
        chk("R8 still no request", 32'(mem_req), 32'd0);
        wr(4'h5, 2'd0, 32'h25);
        rd(4'h5, 2'd0, v); chk("R8 stored modulo 32", v, 32'd5);
        rd(4'h6, 2'd1, v); chk("R8 halt cleared", v, 32'h0004);
        rd(4'h4, 2'd0, v); chk("R8 current advanced", v, 32'd3);
        chk("R8 fetch resumes", mem_addr, 32'h1018);

        // Entries 3 and 4, then the empty entry 5
        tick(3);
        repeat (2) strobe();
        tick(3);
        repeat (3) strobe();
        tick(3);
        chk("R13 waiting not counting", 32'(xfer_active), 32'd0);
        chk("R13 no request", 32'(mem_req), 32'd0);
        rd(4'h4, 2'd0, v); chk("R13 current stays 5", v, 32'd5);
        repeat (2) strobe();
        rd(4'h4, 2'd0, v); chk("R13 strobes ignored", v, 32'd5);
        rd(4'h6, 2'd1, v); chk("R13 not halted", v, 32'h000C);

        // Stop
        wr(4'hB, 2'd0, 32'h0C);
        rd(4'h6, 2'd1, v); chk("R11 halted on stop", v, 32'h000D);
        chk("R11 request dropped", 32'(mem_req), 32'd0);
        rd(4'h4, 2'd2, v); chk("R14 packed read", v, 32'h000D_0505);

        // Ring B: full wrap with last-valid 31, no enables
        wr(4'h5, 2'd0, 32'h1F);
        wr(4'h0, 2'd2, 32'h4000);
        wr(4'hB, 2'd0, 32'h01);
        rd(4'h6, 2'd1, v); chk("R3 restart clears halted", v, 32'h000C);
        chk("R10 irq gated by enables", 32'(irq), 32'd0);
        for (int k = 0; k < 31; k++) begin
            tick(3);
            strobe();
        end
        rd(4'h4, 2'd0, v); chk("R6 current reaches 31", v, 32'd31);
        rd(4'hA, 2'd0, v); chk("R6 prefetch wraps to 0", v, 32'd0);
        tick(3);
        strobe();
        rd(4'h6, 2'd1, v); chk("R7 halt at 31", v, 32'h000F);

        // Resume to entry 0, then register reset during the fetch
        wr(4'h5, 2'd0, 32'h00);
        chk("R8 resume fetch wraps", mem_addr, 32'h4000);
        wr(4'hB, 2'd0, 32'h02);
        chk("R12 fetch abandoned", 32'(mem_req), 32'd0);
        rd(4'h0, 2'd2, v); chk("R12 base cleared", v, 32'd0);
        rd(4'h4, 2'd2, v); chk("R12 packed reset view", v, 32'h0001_0000);
        rd(4'hB, 2'd0, v); chk("R12 control cleared", v, 32'd0);
        chk("R12 irq low", 32'(irq), 32'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule